// File: doc/BRIEF.md
# Forward-Euler Integrator for y'' + 3xy' + 3y = 0

This block integrates the linear second-order equation y'' + 3·x·y' + 3·y = 0 with fixed-step forward Euler updates. A caller supplies a starting point x, the starting value y, the starting slope u = y', a step dx and an end bound a, all in signed Q16.16 fixed point. It then pulses `start`. The block steps x, u and y together until the stepped x is no longer below the bound. It then returns the final y together with a one-cycle `done` pulse.

A single signed multiplier is shared across the six products of each step. A small controller sequences it and parks the partial products in holding registers, so every step takes the same number of cycles. An iteration counter guards against a bound that is never reached, which happens when dx is zero or negative. When the count runs out, the run stops and raises `timeout`.

Top module: `ode_euler_solver`

## Requirements
- R1: While idle, a cycle with `start` high captures xInit, yInit, uInit, dxStep and aBound, and `busy` is high from the next cycle on.
- R2: Each step forms xNext = x + dx with 32-bit wrap. The loop continues while xNext < a, compared as signed values. At least one step always runs.
- R3: Each step forms uNext = u − T − S. T = mul(mul(mul(3,x),u),dx) and S = mul(mul(3,y),dx), where mul(p,q) takes the 64-bit signed product, shifts it arithmetically right by 16 (floor) and keeps the low 32 bits. Sums and differences wrap at 32 bits.
- R4: Each step forms yNext = y + mul(u,dx), using the u from the start of that step. x, u and y are replaced together at the end of the step.
- R5: A run of N steps raises `done` exactly 7·N cycles after the clock edge that captured `start`.
- R6: `done` is high for exactly one cycle, with `busy` low. `yOut` carries the final y from that cycle until the next accepted start.
- R7: A `start` pulse while `busy` is high is ignored. The run in progress keeps its operands and its timing, and no extra `done` occurs.
- R8: If the 2^ITER_LIMIT_W-th step still has xNext < a, the run stops after that step. `done` pulses and `timeout` reads 1 until the next accepted start. A run that ends normally leaves `timeout` at 0.
- R9: A synchronous active-high `rst` returns the block to idle, with `busy`, `done`, `timeout` and `yOut` all at 0, even in the middle of a run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a run; taken only when idle |
| xInit | input | DATA_W | Starting x, Q16.16 |
| yInit | input | DATA_W | Starting y, Q16.16 |
| uInit | input | DATA_W | Starting y', Q16.16 |
| dxStep | input | DATA_W | Step size, Q16.16 |
| aBound | input | DATA_W | Interval end, Q16.16 |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| timeout | output | 1 | Last run hit the step limit |
| yOut | output | DATA_W | Final y, Q16.16 |

## Verification
The result of a run of N steps is due 7·N cycles after the edge that takes `start`. The bench's model counts N from the same update rules before it drives the run. The scoreboard entry carries that due cycle, and the monitor compares the cycle count at the moment `done` appears against it. The monitor also checks one cycle later that `done` has dropped and `yOut` has held. The bench drives and samples on the falling edge, so every comparison sees settled register outputs.

// File: rtl/ode_pkg.sv
package ode_pkg;

  // Which of the six products the shared multiplier forms this cycle.
  typedef enum logic [2:0] {
    MS_3X   = 3'd0,  // 3 * x            -> holdA
    MS_XU   = 3'd1,  // holdA * u        -> holdA
    MS_XUDX = 3'd2,  // holdA * dx       -> holdA
    MS_3Y   = 3'd3,  // 3 * y            -> holdB
    MS_YDX  = 3'd4,  // holdB * dx       -> holdB
    MS_UDX  = 3'd5   // u * dx           -> holdC
  } mulStep_t;

  localparam int unsigned LAST_STEP = 5;

  typedef struct packed {
    logic     load;    // capture the operands
    logic     mulEn;   // write the product selected by step
    mulStep_t step;
    logic     update;  // commit x, u, y together
  } ctrlStrb_t;

endpackage

// File: rtl/ode_dpath.sv
module ode_dpath
  import ode_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int FRAC_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrlStrb_t         strb,
  input  logic [DATA_W-1:0] xInit,
  input  logic [DATA_W-1:0] yInit,
  input  logic [DATA_W-1:0] uInit,
  input  logic [DATA_W-1:0] dxStep,
  input  logic [DATA_W-1:0] aBound,
  output logic              contFlag,
  output logic [DATA_W-1:0] yOut
);

  localparam int PROD_W = 2 * DATA_W;
  localparam logic signed [DATA_W-1:0] THREE =
    {{(DATA_W-FRAC_W-2){1'b0}}, 2'b11, {FRAC_W{1'b0}}};

  logic signed [DATA_W-1:0] xReg, yReg, uReg, dxReg, aReg;
  logic signed [DATA_W-1:0] holdA, holdB, holdC;
  logic signed [DATA_W-1:0] mulA, mulB, mulQ, xNext;
  logic signed [PROD_W-1:0] prodFull;
  logic                     prodUnused;

  // Operand steering for the single shared multiplier.
  always_comb begin
    mulA = THREE;
    mulB = xReg;
    unique case (strb.step)
      MS_3X:   begin mulA = THREE; mulB = xReg;  end
      MS_XU:   begin mulA = holdA; mulB = uReg;  end
      MS_XUDX: begin mulA = holdA; mulB = dxReg; end
      MS_3Y:   begin mulA = THREE; mulB = yReg;  end
      MS_YDX:  begin mulA = holdB; mulB = dxReg; end
      MS_UDX:  begin mulA = uReg;  mulB = dxReg; end
      default: begin mulA = THREE; mulB = xReg;  end
    endcase
  end

  assign prodFull   = mulA * mulB;
  assign mulQ       = prodFull[FRAC_W+DATA_W-1:FRAC_W];
  assign prodUnused = ^{prodFull[PROD_W-1:FRAC_W+DATA_W], prodFull[FRAC_W-1:0]};

  assign xNext    = xReg + dxReg;
  assign contFlag = xNext < aReg;
  assign yOut     = yReg;

  always_ff @(posedge clk) begin
    if (rst) begin
      xReg  <= '0;
      yReg  <= '0;
      uReg  <= '0;
      dxReg <= '0;
      aReg  <= '0;
      holdA <= '0;
      holdB <= '0;
      holdC <= '0;
    end else if (strb.load) begin
      xReg  <= xInit;
      yReg  <= yInit;
      uReg  <= uInit;
      dxReg <= dxStep;
      aReg  <= aBound;
    end else if (strb.update) begin
      xReg <= xNext;
      uReg <= uReg - holdA - holdB;
      yReg <= yReg + holdC;
    end else if (strb.mulEn) begin
      unique case (strb.step)
        MS_3X, MS_XU, MS_XUDX: holdA <= mulQ;
        MS_3Y, MS_YDX:         holdB <= mulQ;
        MS_UDX:                holdC <= mulQ;
        default:               holdA <= mulQ;
      endcase
    end
  end

  // R7: the bound and step may change only through a load
  a_r7_bound_stable: assert property (@(posedge clk) disable iff (rst)
    !strb.load |=> ($stable(aReg) && $stable(dxReg)));

  // R4: between commits the state variables keep their values
  a_r4_state_hold: assert property (@(posedge clk) disable iff (rst)
    (!strb.load && !strb.update) |=> ($stable(xReg) && $stable(yReg) && $stable(uReg)));

endmodule

// File: rtl/ode_ctrl.sv
module ode_ctrl
  import ode_pkg::*;
#(
  parameter int ITER_LIMIT_W = 20
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      start,
  input  logic      contFlag,
  output ctrlStrb_t strb,
  output logic      busy,
  output logic      done,
  output logic      timeout
);

  typedef enum logic [1:0] {ST_IDLE, ST_MUL, ST_UPD} state_t;

  state_t                  state;
  mulStep_t                stepCnt;
  logic [ITER_LIMIT_W-1:0] iterCnt;
  logic                    lastIter;
  logic                    doneQ, timeoutQ;

  assign lastIter = &iterCnt;
  assign busy     = (state != ST_IDLE);
  assign done     = doneQ;
  assign timeout  = timeoutQ;

  always_comb begin
    strb.load   = (state == ST_IDLE) && start;
    strb.mulEn  = (state == ST_MUL);
    strb.step   = stepCnt;
    strb.update = (state == ST_UPD);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      stepCnt  <= MS_3X;
      iterCnt  <= '0;
      doneQ    <= 1'b0;
      timeoutQ <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      unique case (state)
        ST_IDLE: if (start) begin
          state    <= ST_MUL;
          stepCnt  <= MS_3X;
          iterCnt  <= '0;
          timeoutQ <= 1'b0;
        end
        ST_MUL: begin
          if (stepCnt == mulStep_t'(LAST_STEP)) state <= ST_UPD;
          else stepCnt <= mulStep_t'(stepCnt + 3'd1);
        end
        ST_UPD: begin
          if (!contFlag || lastIter) begin
            state    <= ST_IDLE;
            doneQ    <= 1'b1;
            timeoutQ <= contFlag && lastIter;
          end else begin
            state   <= ST_MUL;
            stepCnt <= MS_3X;
            iterCnt <= iterCnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R6: done lasts one cycle and coincides with idle
  a_r6_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r6_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R1: an accepted start makes the block busy on the next cycle
  a_r1_start_busy: assert property (@(posedge clk) disable iff (rst)
    (!busy && start) |=> busy);

  // R7: a run cannot end outside a commit cycle, whatever start does
  a_r7_busy_holds: assert property (@(posedge clk) disable iff (rst)
    (busy && !strb.update) |=> busy);

  // R8: a timeout appears only together with the end-of-run pulse
  a_r8_timeout_with_done: assert property (@(posedge clk) disable iff (rst)
    $rose(timeout) |-> done);

  // R2: a commit with the continue flag set and count left keeps the run going
  a_r2_loop_continues: assert property (@(posedge clk) disable iff (rst)
    (strb.update && contFlag && !lastIter) |=> (busy && !done));

endmodule

// File: rtl/ode_euler_solver.sv
module ode_euler_solver
  import ode_pkg::*;
#(
  parameter int DATA_W       = 32,
  parameter int FRAC_W       = 16,
  parameter int ITER_LIMIT_W = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [DATA_W-1:0] xInit,
  input  logic [DATA_W-1:0] yInit,
  input  logic [DATA_W-1:0] uInit,
  input  logic [DATA_W-1:0] dxStep,
  input  logic [DATA_W-1:0] aBound,
  output logic              busy,
  output logic              done,
  output logic              timeout,
  output logic [DATA_W-1:0] yOut
);

  ctrlStrb_t strb;
  logic      contFlag;

  ode_ctrl #(.ITER_LIMIT_W(ITER_LIMIT_W)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .contFlag (contFlag),
    .strb     (strb),
    .busy     (busy),
    .done     (done),
    .timeout  (timeout)
  );

  ode_dpath #(.DATA_W(DATA_W), .FRAC_W(FRAC_W)) u_dpath (
    .clk      (clk),
    .rst      (rst),
    .strb     (strb),
    .xInit    (xInit),
    .yInit    (yInit),
    .uInit    (uInit),
    .dxStep   (dxStep),
    .aBound   (aBound),
    .contFlag (contFlag),
    .yOut     (yOut)
  );

endmodule

// File: tb/sim_ode_euler_solver.sv
module sim_ode_euler_solver;

  localparam int LIM_W = 5;
  localparam int LIMIT = 1 << LIM_W;
  localparam logic [31:0] THREE = 32'h0003_0000;

  typedef struct {
    logic [31:0] y;
    logic        tmo;
    int          lat;
    int          startCyc;
    string       name;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [31:0] xInit = '0, yInit = '0, uInit = '0, dxStep = '0, aBound = '0;
  logic busy, done, timeout;
  logic [31:0] yOut;

  int nRun = 0, nFail = 0, cycCnt = 0;
  exp_t sb[$];

  always #2 clk = ~clk;  // 250 MHz
  always @(posedge clk) cycCnt <= cycCnt + 1;

  ode_euler_solver #(.DATA_W(32), .FRAC_W(16), .ITER_LIMIT_W(LIM_W)) u0 (
    .clk(clk), .rst(rst), .start(start), .xInit(xInit), .yInit(yInit),
    .uInit(uInit), .dxStep(dxStep), .aBound(aBound), .busy(busy),
    .done(done), .timeout(timeout), .yOut(yOut));

  task automatic chk(input logic ok, input string tag, input longint act, input longint expv);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expv);
    end
  endtask

  function automatic logic [31:0] mulq(input logic [31:0] p, input logic [31:0] q);
    longint pr;
    pr = longint'($signed(p)) * longint'($signed(q));
    return pr[47:16];
  endfunction

  // Reference model built from R2, R3, R4 and R8.
  function automatic void model(input logic [31:0] x0, y0, u0v, dx, a,
                                output logic [31:0] yf, output logic tmo, output int n);
    logic [31:0] x, y, u, t, s, w, xn;
    x = x0; y = y0; u = u0v; tmo = 1'b0; n = 0;
    for (int i = 1; i <= LIMIT; i++) begin
      t  = mulq(mulq(mulq(THREE, x), u), dx);
      s  = mulq(mulq(THREE, y), dx);
      w  = mulq(u, dx);
      xn = x + dx;
      u  = u - t - s;
      y  = y + w;
      x  = xn;
      n  = i;
      if (!($signed(xn) < $signed(a))) break;
      if (i == LIMIT) tmo = 1'b1;
    end
    yf = y;
  endfunction

  // Driver: predict, push to scoreboard, pulse start, optionally poke start while busy.
  task automatic runCase(input string name, input logic [31:0] x0, y0, u0v, dx, a,
                         input bit pokeBusy);
    exp_t e;
    int n;
    model(x0, y0, u0v, dx, a, e.y, e.tmo, n);
    e.lat = 7 * n;
    e.name = name;
    @(negedge clk);
    xInit = x0; yInit = y0; uInit = u0v; dxStep = dx; aBound = a;
    start = 1'b1;
    e.startCyc = cycCnt + 1;
    sb.push_back(e);
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1, {"R1 busy after start ", name}, longint'(busy), 1);
    if (pokeBusy) begin
      repeat (3) @(negedge clk);
      xInit = 32'h0040_0000; yInit = 32'h7000_0000; uInit = 32'h1234_5678;
      dxStep = 32'h0000_0001; aBound = 32'h7FFF_0000;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // Monitor: pop and compare at each done pulse.
  initial begin
    exp_t e;
    logic [31:0] yHeld;
    forever begin
      @(negedge clk);
      if (!rst && done === 1'b1) begin
        if (sb.size() == 0) begin
          chk(1'b0, "R7 unexpected done", 1, 0);
        end else begin
          e = sb.pop_front();
          chk(yOut === e.y, {"R3 R4 final y ", e.name}, longint'(yOut), longint'(e.y));
          chk(timeout === e.tmo, {"R8 timeout flag ", e.name}, longint'(timeout), longint'(e.tmo));
          chk(cycCnt - e.startCyc == e.lat, {"R5 R2 latency ", e.name},
              longint'(cycCnt - e.startCyc), longint'(e.lat));
          chk(busy === 1'b0, {"R6 idle with done ", e.name}, longint'(busy), 0);
          yHeld = yOut;
          @(negedge clk);
          chk(done === 1'b0, {"R6 done one cycle ", e.name}, longint'(done), 0);
          chk(yOut === yHeld, {"R6 yOut held ", e.name}, longint'(yOut), longint'(yHeld));
        end
      end
    end
  end

  // Watchdog
  initial begin
    wait (cycCnt > 100000);
    nRun++; nFail++;
    $display("FAIL watchdog expired actual=%0d expected<100000", cycCnt);
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9: reset state
    chk(busy === 1'b0, "R9 busy after reset", longint'(busy), 0);
    chk(done === 1'b0, "R9 done after reset", longint'(done), 0);
    chk(timeout === 1'b0, "R9 timeout after reset", longint'(timeout), 0);
    chk(yOut === 32'h0, "R9 yOut after reset", longint'(yOut), 0);

    runCase("four steps",  32'h0, 32'h0001_0000, 32'h0, 32'h0000_4000, 32'h0001_0000, 0);
    runCase("negative u",  32'h0, 32'h0000_8000, 32'hFFFF_0000, 32'h0000_2000, 32'h0000_8000, 0);
    runCase("one step R2", 32'h0, 32'h0002_0000, 32'h0000_C000, 32'h0001_0000, 32'h0000_8000, 0);
    runCase("neg start",   32'hFFFE_0000, 32'hFFFE_8000, 32'h0000_C000, 32'h0000_1000, 32'hFFFF_0000, 0);
    runCase("busy poke R7", 32'h0, 32'h0001_0000, 32'h0000_4000, 32'h0000_4000, 32'h0001_0000, 1);
    runCase("zero dx R8",  32'h0001_0000, 32'h0001_8000, 32'h0000_2000, 32'h0, 32'h0002_0000, 0);
    runCase("after tmo R8", 32'h0, 32'h0001_0000, 32'h0, 32'h0000_8000, 32'h0000_8000, 0);

    // R9: reset in the middle of a run
    @(negedge clk);
    xInit = 32'h0; yInit = 32'h0001_0000; uInit = 32'h0;
    dxStep = 32'h0000_1000; aBound = 32'h0001_0000;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (10) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(busy === 1'b0, "R9 busy after mid-run reset", longint'(busy), 0);
    chk(done === 1'b0, "R9 done after mid-run reset", longint'(done), 0);
    chk(yOut === 32'h0, "R9 yOut after mid-run reset", longint'(yOut), 0);
    repeat (120) @(negedge clk);
    chk(busy === 1'b0, "R9 stays idle after reset", longint'(busy), 0);

    runCase("post reset", 32'h0, 32'h0001_0000, 32'hFFFF_8000, 32'h0000_4000, 32'h0000_C000, 0);

    chk(sb.size() == 0, "R6 every run reported", longint'(sb.size()), 0);
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule